// File: doc/BRIEF.md
# VLIW Variable-Length Instruction Aligner

This block sits in the fetch stage of a VLIW core whose instructions are compressed to one of four lengths. It takes 64-byte instruction lines through a valid/ready handshake and hands on one whole instruction per cycle, left-aligned at bit 0, together with its size code. Instructions are packed back to back with no padding, so an instruction can start in one line and finish in the next. The aligner keeps the unused tail of each line and appends the next line directly after it.

No instruction states its own length. The length of each instruction comes from a 2-bit hint held in the top two bits of the instruction before it. The first instruction after reset or after a flush takes its size from a start-code input. A flush throws away everything held in the block. Alignment then restarts at a chosen byte offset inside the next line, which is how a redirected fetch is taken up. The output is held in a register, so extraction has a pipeline stage of its own.

Top module: `vliw_aligner`

## Requirements
- R1: While reset is high and in the first cycle after it, `insn_valid` is 0 and `line_ready` is 1.
- R2: Size code 00 means a 2-bit instruction, 01 means 26 bits, 10 means 34 bits and 11 means 44 bits. `insn_code` carries the code of the presented instruction. The bits of `insn_bits` at or above that length are 0.
- R3: Stream order runs from line bit 0 upward, so byte k of a line holds stream bits 8k to 8k+7. The first stream bit of an instruction appears on `insn_bits[0]`. Bits [len-1:len-2] of an instruction give the size code of the instruction that follows it. For a 2-bit instruction this is its whole content.
- R4: Each accepted line is appended after the unused bits of earlier lines. Instructions that straddle a line boundary come out whole and in stream order, with none lost or repeated.
- R5: After reset or flush, the first instruction's size code is taken from `start_code`.
- R6: The buffer holds 1024 bits. `line_ready` is 0 whenever more than 512 bits are buffered, and it is also 0 while `flush` is high.
- R7: `insn_valid` stays 0 while fewer bits are buffered than the pending instruction's length. A trailing fragment shorter than that is never presented.
- R8: While `insn_valid` is 1 and `insn_ready` is 0, `insn_bits` and `insn_code` stay unchanged in the next cycle.
- R9: A flush drops all buffered bits and any presented instruction, so `insn_valid` is 0 in the next cycle. The first line accepted after the flush is used from byte `flush_offset` onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard buffered state and restart alignment |
| flush_offset | input | 6 | Byte offset within the next line where alignment restarts |
| start_code | input | 2 | Size code of the first instruction after reset or flush |
| line_valid | input | 1 | An instruction line is offered |
| line_ready | output | 1 | The buffer can take a full line this cycle |
| line_data | input | 512 | Instruction line, byte 0 in bits [7:0] |
| insn_valid | output | 1 | An aligned instruction is presented |
| insn_ready | input | 1 | The consumer takes the presented instruction |
| insn_bits | output | 44 | Aligned instruction, first stream bit at bit 0, zero above its length |
| insn_code | output | 2 | Size code of the presented instruction |

## Verification
The bench builds bit-exact streams from a table of size codes. The table mixes runs of 2-bit instructions with 44-bit ones, so some instructions fall entirely inside a line and some straddle a boundary. Those streams are fed with lines back to back and with gaps, against a consumer that is always ready, ready every other cycle, or ready in short bursts. This separates errors in the length or hint decode from errors in the append and shift arithmetic under stalls. Restart offsets of 0, 1, 5, 17, 40 and 63 bytes, with garbage placed ahead of the offset, show whether the skip is applied to the right line. A 44-bit first instruction that begins 8 bits before the end of a line shows that a partial instruction is held back. A long consumer stall shows the output holding steady and the input being throttled.

// File: rtl/valn_pkg.sv
package valn_pkg;

  typedef logic [1:0] size_code_t;

  localparam int unsigned LEN_NOP  = 2;
  localparam int unsigned LEN_S    = 26;
  localparam int unsigned LEN_M    = 34;
  localparam int unsigned LEN_L    = 44;
  localparam int unsigned MAX_LEN  = LEN_L;
  localparam int unsigned LEN_BITS = $clog2(MAX_LEN + 1);

  function automatic logic [LEN_BITS-1:0] code_len(size_code_t c);
    case (c)
      2'b00:   code_len = LEN_BITS'(LEN_NOP);
      2'b01:   code_len = LEN_BITS'(LEN_S);
      2'b10:   code_len = LEN_BITS'(LEN_M);
      default: code_len = LEN_BITS'(LEN_L);
    endcase
  endfunction

endpackage

// File: rtl/valn_size_lut.sv
module valn_size_lut
  import valn_pkg::*;
#(
  parameter int LEN_W = LEN_BITS
) (
  input  size_code_t       code,
  output logic [LEN_W-1:0] len
);

  localparam int NCODES = 4;

  logic [LEN_W-1:0] table_q [NCODES];

  generate
    for (genvar k = 0; k < NCODES; k++) begin : g_len
      assign table_q[k] = LEN_W'(code_len(size_code_t'(k)));
    end
  endgenerate

  assign len = table_q[code];

endmodule

// File: rtl/valn_bitbuf.sv
module valn_bitbuf #(
  parameter int LINE_BITS = 512,
  parameter int BUF_BITS  = 1024,
  parameter int CNT_W     = $clog2(BUF_BITS + 1),
  parameter int LEN_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear,
  input  logic                 push,
  input  logic [LINE_BITS-1:0] line,
  input  logic [CNT_W-1:0]     skip,
  input  logic                 pop,
  input  logic [LEN_W-1:0]     pop_len,
  output logic [BUF_BITS-1:0]  data,
  output logic [CNT_W-1:0]     count,
  output logic                 room
);

  localparam int PAD      = BUF_BITS - LINE_BITS;
  localparam int ROOM_MAX = BUF_BITS - LINE_BITS;

  logic [BUF_BITS-1:0] rem_data;
  logic [CNT_W-1:0]    rem_cnt;
  logic [BUF_BITS-1:0] line_ext;
  logic [BUF_BITS-1:0] line_pos;
  logic [CNT_W-1:0]    line_cnt;
  logic [BUF_BITS-1:0] nxt_data;
  logic [CNT_W-1:0]    nxt_cnt;

  // drop the consumed instruction from the bottom first
  always_comb begin
    if (pop) begin
      rem_data = data >> pop_len;
      rem_cnt  = count - CNT_W'(pop_len);
    end else begin
      rem_data = data;
      rem_cnt  = count;
    end
  end

  // then place the new line right above what is left
  generate
    if (PAD > 0) begin : g_pad
      assign line_ext = {{PAD{1'b0}}, line} >> skip;
    end else begin : g_nopad
      assign line_ext = line >> skip;
    end
  endgenerate

  always_comb begin
    if (push) begin
      line_pos = line_ext << rem_cnt;
      line_cnt = CNT_W'(LINE_BITS) - skip;
    end else begin
      line_pos = '0;
      line_cnt = '0;
    end
    nxt_data = rem_data | line_pos;
    nxt_cnt  = rem_cnt + line_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      data  <= '0;
      count <= '0;
    end else begin
      data  <= nxt_data;
      count <= nxt_cnt;
    end
  end

  assign room = (count <= CNT_W'(ROOM_MAX));

endmodule

// File: rtl/valn_out_stage.sv
module valn_out_stage
  import valn_pkg::*;
#(
  parameter int INSN_W = 44,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              take,
  input  logic [INSN_W-1:0] din,
  input  logic [LEN_W-1:0]  len,
  input  size_code_t        code_in,
  output logic              valid,
  output logic [INSN_W-1:0] bits,
  output size_code_t        code
);

  logic [INSN_W-1:0] keep;

  generate
    for (genvar b = 0; b < INSN_W; b++) begin : g_keep
      assign keep[b] = (int'(len) > b);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid <= 1'b0;
      bits  <= '0;
      code  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      bits  <= din & keep;
      code  <= code_in;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vliw_aligner.sv
module vliw_aligner
  import valn_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int INSN_W     = 44,
  parameter int LEN_W      = 6
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                flush,
  input  logic [$clog2(LINE_BYTES)-1:0]       flush_offset,
  input  logic [1:0]                          start_code,
  input  logic                                line_valid,
  output logic                                line_ready,
  input  logic [LINE_BYTES*8-1:0]             line_data,
  output logic                                insn_valid,
  input  logic                                insn_ready,
  output logic [INSN_W-1:0]                   insn_bits,
  output logic [1:0]                          insn_code
);

  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int BUF_BITS  = 2 * LINE_BITS;
  localparam int CNT_W     = $clog2(BUF_BITS + 1);
  localparam int OFF_W     = $clog2(LINE_BYTES);

  logic [BUF_BITS-1:0] buf_data;
  logic [CNT_W-1:0]    buf_count;
  logic                buf_room;
  logic [CNT_W-1:0]    skip_q;
  size_code_t          pend_code;
  logic [LEN_W-1:0]    pend_len;
  logic [BUF_BITS-1:0] hint_sh;
  size_code_t          next_code;
  logic                have_bits;
  logic                slot_free;
  logic                pop;
  logic                push;
  logic                out_valid;
  logic [INSN_W-1:0]   out_bits;
  size_code_t          out_code;

  valn_size_lut #(.LEN_W(LEN_W)) u_lut (
    .code (pend_code),
    .len  (pend_len)
  );

  assign have_bits  = (buf_count >= CNT_W'(pend_len));
  assign slot_free  = !out_valid || insn_ready;
  assign pop        = !flush && have_bits && slot_free;
  assign line_ready = !flush && buf_room;
  assign push       = line_valid && line_ready;

  // the hint of the instruction being taken sits in its top two bits
  assign hint_sh   = buf_data >> (pend_len - LEN_W'(2));
  assign next_code = hint_sh[1:0];

  valn_bitbuf #(
    .LINE_BITS (LINE_BITS),
    .BUF_BITS  (BUF_BITS),
    .CNT_W     (CNT_W),
    .LEN_W     (LEN_W)
  ) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clear   (flush),
    .push    (push),
    .line    (line_data),
    .skip    (skip_q),
    .pop     (pop),
    .pop_len (pend_len),
    .data    (buf_data),
    .count   (buf_count),
    .room    (buf_room)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_code <= start_code;
      skip_q    <= '0;
    end else if (flush) begin
      pend_code <= start_code;
      skip_q    <= CNT_W'({flush_offset, 3'b000});
    end else begin
      if (pop)  pend_code <= next_code;
      if (push) skip_q    <= '0;
    end
  end

  valn_out_stage #(
    .INSN_W (INSN_W),
    .LEN_W  (LEN_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .clear   (flush),
    .load    (pop),
    .take    (insn_ready),
    .din     (buf_data[INSN_W-1:0]),
    .len     (pend_len),
    .code_in (pend_code),
    .valid   (out_valid),
    .bits    (out_bits),
    .code    (out_code)
  );

  assign insn_valid = out_valid;
  assign insn_bits  = out_bits;
  assign insn_code  = out_code;

  logic unused_off;
  assign unused_off = ^OFF_W;

endmodule

// File: rtl/valn_checker.sv
module valn_checker
  import valn_pkg::*;
#(
  parameter int INSN_W    = 44,
  parameter int LINE_BITS = 512,
  parameter int BUF_BITS  = 1024,
  parameter int CNT_W     = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              line_ready,
  input logic              insn_valid,
  input logic              insn_ready,
  input logic [INSN_W-1:0] insn_bits,
  input logic [1:0]        insn_code,
  input logic [CNT_W-1:0]  buf_count
);

  // R1: output empty and buffer clear right after reset
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!insn_valid && buf_count == '0));

  // R2: nothing above the instruction length
  p_masked_r2: assert property (@(posedge clk) disable iff (rst)
    insn_valid |-> ((insn_bits >> code_len(insn_code)) == '0));

  // R6: no line accepted when a full line would not fit
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (buf_count > CNT_W'(BUF_BITS - LINE_BITS)) |-> !line_ready);

  // R6: buffer fill never exceeds capacity
  p_cap_r6: assert property (@(posedge clk) disable iff (rst)
    buf_count <= CNT_W'(BUF_BITS));

  // R8: a stalled instruction holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (insn_valid && !insn_ready && !flush) |=>
      (insn_valid && $stable(insn_bits) && $stable(insn_code)));

  // R9: flush empties the output
  p_flush_empty_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> !insn_valid);

endmodule

bind vliw_aligner valn_checker #(
  .INSN_W    (INSN_W),
  .LINE_BITS (LINE_BITS),
  .BUF_BITS  (BUF_BITS),
  .CNT_W     (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .flush      (flush),
  .line_ready (line_ready),
  .insn_valid (insn_valid),
  .insn_ready (insn_ready),
  .insn_bits  (insn_bits),
  .insn_code  (insn_code),
  .buf_count  (buf_count)
);

// File: tb/sim_vliw_aligner.sv
module sim_vliw_aligner;

  localparam int CLK_PERIOD = 10;
  localparam int LBYTES     = 64;
  localparam int LBITS      = LBYTES * 8;
  localparam int W          = 44;
  localparam int MAXEXP     = 256;

  // size code stream and the length each code must produce (R2)
  localparam logic [1:0] CODES [16] = '{2'd1, 2'd3, 2'd0, 2'd0, 2'd2, 2'd3, 2'd1, 2'd0,
                                        2'd3, 2'd3, 2'd2, 2'd0, 2'd1, 2'd2, 2'd0, 2'd3};
  localparam int         LENS  [4]  = '{2, 26, 34, 44};
  // scenarios: rotation, byte offset, lines, output-ready mode, gapped input
  localparam int SCEN [6][5] = '{'{0, 0, 2, 0, 0},  '{3, 5, 3, 1, 0},  '{7, 17, 3, 0, 1},
                                 '{2, 63, 2, 2, 1}, '{9, 1, 4, 1, 1},  '{12, 40, 3, 2, 0}};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flush = 1'b0;
  logic [5:0]       flush_offset = '0;
  logic [1:0]       start_code = '0;
  logic             line_valid = 1'b0;
  logic             line_ready;
  logic [LBITS-1:0] line_data = '0;
  logic             insn_valid;
  logic             insn_ready = 1'b0;
  logic [W-1:0]     insn_bits;
  logic [1:0]       insn_code;

  vliw_aligner u0 (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush),
    .flush_offset (flush_offset),
    .start_code   (start_code),
    .line_valid   (line_valid),
    .line_ready   (line_ready),
    .line_data    (line_data),
    .insn_valid   (insn_valid),
    .insn_ready   (insn_ready),
    .insn_bits    (insn_bits),
    .insn_code    (insn_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  logic [4095:0] stream;
  logic [W-1:0]  exp_bits [MAXEXP];
  logic [1:0]    exp_code [MAXEXP];
  int            n_exp;
  int            li;
  int            got;

  task automatic check(string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // lay out a stream of instructions from the code table
  task automatic build(int rot, int off, int nl);
    int pos;
    stream = '0;
    for (int b = 0; b < off * 8; b++) stream[b] = 1'b1;
    pos = off * 8;
    n_exp = 0;
    for (int i = 0; i < MAXEXP; i++) begin
      logic [1:0] c;
      logic [1:0] nc;
      logic [W-1:0] v;
      int len;
      c   = CODES[(rot + i) % 16];
      nc  = CODES[(rot + i + 1) % 16];
      len = LENS[c];
      if (pos + len > nl * LBITS) break;
      v = '0;
      for (int j = 0; j < len - 2; j++) v[j] = (((i * 7 + j * 3 + rot) % 5) > 1);
      v[len-2] = nc[0];
      v[len-1] = nc[1];
      for (int j = 0; j < len; j++) stream[pos + j] = v[j];
      exp_bits[n_exp] = v;
      exp_code[n_exp] = c;
      n_exp++;
      pos += len;
    end
  endtask

  task automatic do_flush(int off, logic [1:0] sc);
    @(negedge clk);
    flush = 1'b1; flush_offset = 6'(off); start_code = sc;
    line_valid = 1'b0; insn_ready = 1'b0;
    @(negedge clk);
    flush = 1'b0;
    check("R9 output empty after flush", 64'(insn_valid), 64'd0);
    li = 0; got = 0;
  endtask

  // feed the remaining lines and compare every emitted instruction
  task automatic feed_drain(int nl, int rmode, int imode, string first_tag);
    int cyc;
    int extra;
    cyc = 0;
    while ((li < nl || got < n_exp) && cyc < 4000) begin
      line_valid = (li < nl) && (imode == 0 || (cyc % 3) != 1);
      line_data  = (li < nl) ? stream[li * LBITS +: LBITS] : '0;
      case (rmode)
        0:       insn_ready = 1'b1;
        1:       insn_ready = ((cyc % 2) == 0);
        default: insn_ready = ((cyc % 5) < 2);
      endcase
      #1;
      if (line_valid && line_ready) li++;
      if (insn_valid && insn_ready) begin
        if (got < n_exp) begin
          check((got == 0) ? first_tag : "R3 R4 bits", 64'(insn_bits), 64'(exp_bits[got]));
          check("R2 code", 64'(insn_code), 64'(exp_code[got]));
        end
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    line_valid = 1'b0;
    insn_ready = 1'b1;
    extra = 0;
    for (int k = 0; k < 20; k++) begin
      #1;
      if (insn_valid) extra++;
      @(negedge clk);
    end
    check("R7 no tail fragment", 64'(extra), 64'd0);
    check("R4 instruction count", 64'(got), 64'(n_exp));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(insn_valid), 64'd0);
    check("R1 ready in reset", 64'(line_ready), 64'd1);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", 64'(insn_valid), 64'd0);
    check("R1 ready after reset", 64'(line_ready), 64'd1);

    // table-driven streams
    for (int s = 0; s < 6; s++) begin
      build(SCEN[s][0], SCEN[s][1], SCEN[s][2]);
      do_flush(SCEN[s][1], CODES[SCEN[s][0]]);
      feed_drain(SCEN[s][2], SCEN[s][3], SCEN[s][4], "R5 first instruction");
    end

    // R6 and R8: consumer stalled, lines keep coming
    build(0, 0, 3);
    do_flush(0, CODES[0]);
    for (int k = 0; k < 8; k++) begin
      line_valid = (li < 3);
      line_data  = stream[li * LBITS +: LBITS];
      insn_ready = 1'b0;
      #1;
      if (line_valid && line_ready) li++;
      @(negedge clk);
    end
    #1;
    check("R6 lines taken under stall", 64'(li), 64'd2);
    check("R6 ready low when full", 64'(line_ready), 64'd0);
    check("R8 valid held", 64'(insn_valid), 64'd1);
    check("R8 bits held", 64'(insn_bits), 64'(exp_bits[0]));
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R8 bits still held", 64'(insn_bits), 64'(exp_bits[0]));
    line_valid = 1'b0;

    // R9: flush from the full state, new stream at a new offset
    build(5, 23, 2);
    do_flush(23, CODES[5]);
    feed_drain(2, 0, 0, "R9 first after flush");

    // R7: 44-bit first instruction with only 8 bits in the first line
    build(1, 63, 2);
    do_flush(63, CODES[1]);
    line_valid = 1'b1;
    line_data  = stream[0 +: LBITS];
    insn_ready = 1'b1;
    #1;
    check("R7 first line accepted", 64'(line_ready), 64'd1);
    @(negedge clk);
    li = 1;
    line_valid = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 6; k++) begin
        #1;
        if (insn_valid) seen++;
        @(negedge clk);
      end
      check("R7 held back partial", 64'(seen), 64'd0);
    end
    feed_drain(2, 0, 0, "R4 straddling first");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule